// File: doc/BRIEF.md
# Edge-Interrupt GPIO Register Controller

This block controls 32 general-purpose pins through a word-addressed register port with 16-bit data. Every control or status function is held in a pair of registers: the low word covers pins 15..0 and the high word covers pins 31..16. Software uses it to choose each pin's direction, set the driven level of output pins and read back the pin levels. It can also arm a per-pin edge interrupt.

Pin inputs pass through a two-flop synchronizer into the system clock domain. An edge is found by comparing the synchronized level with its value one cycle earlier. When an armed pin sees its chosen edge (rising or falling), a sticky flag is set. Flags are cleared by writing ones to them. All 32 flags merge into one active-low interrupt line to the CPU. The block has only a hardware reset.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After hardware reset every register reads zero, `pad_oe` and `pad_out` are all zero and `cpu_irq_n` is 1 (released).
- R2: Word offsets are: 0/1 direction, 2/3 data-in, 4/5 data-out, 6/7 edge select, 8/9 interrupt enable, 0xA/0xB flags. In each pair the even offset holds pins 15..0 (bit i = pin i) and the odd offset holds pins 31..16 (bit i = pin 16+i). The direction, data-out, edge-select and enable words read back exactly what was written.
- R3: A direction bit of 1 sets `pad_oe` for that pin and drives `pad_out` with its data-out bit. A direction bit of 0 clears both `pad_oe` and `pad_out` for the pin, while the data-out bit stays stored and reads back unchanged.
- R4: A data-in word returns, per pin, the two-flop-synchronized `pad_in` level for an input pin and the driven data-out bit for an output pin.
- R5: With its enable bit at 1, a pin whose edge-select bit is 1 sets its flag on a 0-to-1 change of `pad_in`. A pin whose edge-select bit is 0 sets its flag on a 1-to-0 change. The flag is visible three clock edges after the pad changes. With the enable bit at 0, no edge sets the flag.
- R6: A set flag stays set. Writing 1 to a flag bit clears it; writing 0 leaves it unchanged.
- R7: `cpu_irq_n` is 0 while any of the 32 flags is set, and returns to 1 only when all are clear.
- R8: If a pin's edge is detected in the same cycle as a write of 1 to that pin's flag, the flag remains set.
- R9: Writes to the data-in offsets (2, 3) are ignored, and offsets 0xC to 0xF read as zero.
- R10: Read data appears on `bus_rdata` one cycle after the read request and is zero in any cycle that follows no read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | 32 | Raw pin levels |
| pad_out | output | 32 | Driven pin levels |
| pad_oe | output | 32 | Per-pin output enable |
| cpu_irq_n | output | 1 | Combined active-low interrupt |

## Verification
Two events can fall on the same clock edge: a detected pin edge setting a flag, and a software write of 1 clearing that same flag. The bench sets up the collision by counting register stages. It changes the pad level on a falling clock edge and waits two rising edges, so that the edge becomes visible to the detector. It then presents the clearing write so that the write is captured on the third rising edge, together with the event. The flag is then read back and must still be 1. A control case, in which the same clear is written with no edge present, must leave the flag at 0.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_DIR_LO  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_DIR_HI  = 4'h1;
    localparam logic [ADDR_W-1:0] OFS_DIN_LO  = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_DIN_HI  = 4'h3;
    localparam logic [ADDR_W-1:0] OFS_DOUT_LO = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_DOUT_HI = 4'h5;
    localparam logic [ADDR_W-1:0] OFS_EDGE_LO = 4'h6;
    localparam logic [ADDR_W-1:0] OFS_EDGE_HI = 4'h7;
    localparam logic [ADDR_W-1:0] OFS_IEN_LO  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_IEN_HI  = 4'h9;
    localparam logic [ADDR_W-1:0] OFS_FLAG_LO = 4'hA;
    localparam logic [ADDR_W-1:0] OFS_FLAG_HI = 4'hB;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_irq_bank.sv
module gpx_irq_bank #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_sync,
    input  logic [NPINS-1:0] edge_sel,
    input  logic [NPINS-1:0] irq_en,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] flags,
    output logic             irq_n
);
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] flags_q;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        // rising when select is 1, falling when select is 0
        assign hit[p] = irq_en[p] & (edge_sel[p] ? (pin_sync[p] & ~prev_q[p])
                                                 : (~pin_sync[p] & prev_q[p]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            flags_q <= '0;
        end else begin
            prev_q  <= pin_sync;
            // a new event overrides a simultaneous clear
            flags_q <= (flags_q & ~clr_mask) | hit;
        end
    end

    assign flags = flags_q;
    assign irq_n = ~(|flags_q);
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpx_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [2*WORD_W-1:0] pad_in,
    output logic [2*WORD_W-1:0] pad_out,
    output logic [2*WORD_W-1:0] pad_oe,
    output logic                cpu_irq_n
);
    localparam int NPINS = 2 * WORD_W;

    logic [NPINS-1:0] dir_q, dout_q, edge_q, ien_q;
    logic [NPINS-1:0] pin_sync, din_view, clr_mask, flag_vec;
    logic [WORD_W-1:0] rd_word, rdata_q;
    logic wr_req, rd_req;

    assign wr_req = bus_en & bus_we;
    assign rd_req = bus_en & ~bus_we;

    gpx_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            dout_q <= '0;
            edge_q <= '0;
            ien_q  <= '0;
        end else if (wr_req) begin
            case (bus_addr)
                OFS_DIR_LO:  dir_q[WORD_W-1:0]      <= bus_wdata;
                OFS_DIR_HI:  dir_q[NPINS-1:WORD_W]  <= bus_wdata;
                OFS_DOUT_LO: dout_q[WORD_W-1:0]     <= bus_wdata;
                OFS_DOUT_HI: dout_q[NPINS-1:WORD_W] <= bus_wdata;
                OFS_EDGE_LO: edge_q[WORD_W-1:0]     <= bus_wdata;
                OFS_EDGE_HI: edge_q[NPINS-1:WORD_W] <= bus_wdata;
                OFS_IEN_LO:  ien_q[WORD_W-1:0]      <= bus_wdata;
                OFS_IEN_HI:  ien_q[NPINS-1:WORD_W]  <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_mask = '0;
        if (wr_req && bus_addr == OFS_FLAG_LO) clr_mask[WORD_W-1:0]     = bus_wdata;
        if (wr_req && bus_addr == OFS_FLAG_HI) clr_mask[NPINS-1:WORD_W] = bus_wdata;
    end

    gpx_irq_bank #(.NPINS(NPINS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .edge_sel (edge_q),
        .irq_en   (ien_q),
        .clr_mask (clr_mask),
        .flags    (flag_vec),
        .irq_n    (cpu_irq_n)
    );

    assign din_view = (dir_q & dout_q) | (~dir_q & pin_sync);

    always_comb begin
        case (bus_addr)
            OFS_DIR_LO:  rd_word = dir_q[WORD_W-1:0];
            OFS_DIR_HI:  rd_word = dir_q[NPINS-1:WORD_W];
            OFS_DIN_LO:  rd_word = din_view[WORD_W-1:0];
            OFS_DIN_HI:  rd_word = din_view[NPINS-1:WORD_W];
            OFS_DOUT_LO: rd_word = dout_q[WORD_W-1:0];
            OFS_DOUT_HI: rd_word = dout_q[NPINS-1:WORD_W];
            OFS_EDGE_LO: rd_word = edge_q[WORD_W-1:0];
            OFS_EDGE_HI: rd_word = edge_q[NPINS-1:WORD_W];
            OFS_IEN_LO:  rd_word = ien_q[WORD_W-1:0];
            OFS_IEN_HI:  rd_word = ien_q[NPINS-1:WORD_W];
            OFS_FLAG_LO: rd_word = flag_vec[WORD_W-1:0];
            OFS_FLAG_HI: rd_word = flag_vec[NPINS-1:WORD_W];
            default:     rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_req ? rd_word : '0;
    end

    assign bus_rdata = rdata_q;
    assign pad_oe    = dir_q;
    assign pad_out   = dir_q & dout_q;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
    parameter int WORD_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_en,
    input logic                bus_we,
    input logic [3:0]          bus_addr,
    input logic [WORD_W-1:0]   bus_wdata,
    input logic [WORD_W-1:0]   bus_rdata,
    input logic [2*WORD_W-1:0] pad_oe,
    input logic                cpu_irq_n,
    input logic [2*WORD_W-1:0] ien,
    input logic [2*WORD_W-1:0] flags
);
    logic clr_wr;
    assign clr_wr = bus_en && bus_we && (bus_addr == 4'hA || bus_addr == 4'hB);

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == 4'h0) |=> pad_oe[WORD_W-1:0] == $past(bus_wdata)); // R3
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0 && flags == '0) |=> flags == '0); // R5
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_irq_n && !clr_wr) |=> !cpu_irq_n); // R6
    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq_n) |-> $past(clr_wr)); // R7
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr >= 4'hC) |=> bus_rdata == '0); // R9
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_we) |=> bus_rdata == '0); // R10
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .cpu_irq_n (cpu_irq_n),
    .ien       (ien_q),
    .flags     (flag_vec)
);

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_en = 0, bus_we = 0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        cpu_irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    gpio_edge_ctrl u_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .cpu_irq_n(cpu_irq_n)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_en = 1; bus_we = 0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_en = 0;
        d = bus_rdata;
    endtask

    task automatic rd32(input logic [3:0] lo, output logic [31:0] d);
        logic [15:0] l, h;
        rd(lo, l);
        rd(lo + 4'h1, h);
        d = {h, l};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [31:0] v, dir, dout, expv;

        tick(4);
        rst_n = 1;
        tick(2);

        // R1 reset state
        chk("R1 irq released", {31'd0, cpu_irq_n}, 32'd1);
        chk("R1 pad_oe", pad_oe, 32'd0);
        chk("R1 pad_out", pad_out, 32'd0);
        for (int a = 0; a < 12; a++) begin
            rd(a[3:0], r);
            chk($sformatf("R1 reset read ofs %0d", a), {16'd0, r}, 32'd0);
        end

        // R2 readback of writable pairs, low/high mapping
        for (int f = 0; f < 4; f++) begin
            logic [3:0] base;
            base = (f == 0) ? 4'h0 : (f == 1) ? 4'h4 : (f == 2) ? 4'h6 : 4'h8;
            wr(base, 16'h1234 + 16'(f));
            wr(base + 4'h1, 16'hA5C0 + 16'(f));
            rd32(base, v);
            chk($sformatf("R2 readback ofs %0d", base), v, {16'hA5C0 + 16'(f), 16'h1234 + 16'(f)});
        end
        wr(4'h8, 16'h0000); wr(4'h9, 16'h0000);

        // R3 direction gates the pins
        dir = 32'h0F0F_00FF; dout = 32'h3333_5555;
        wr(4'h0, dir[15:0]); wr(4'h1, dir[31:16]);
        wr(4'h4, dout[15:0]); wr(4'h5, dout[31:16]);
        chk("R3 pad_oe follows direction", pad_oe, dir);
        chk("R3 pad_out output pins only", pad_out, dir & dout);
        wr(4'h0, 16'h0); wr(4'h1, 16'h0);
        chk("R3 input pins not enabled", pad_oe, 32'd0);
        chk("R3 input pins not driven", pad_out, 32'd0);
        rd32(4'h4, v);
        chk("R3 data-out stored while input", v, dout);

        // R4 data-in mixes synchronized pads and driven values
        dir = 32'h0F00_00F0; dout = 32'h0000_FFFF;
        wr(4'h0, dir[15:0]); wr(4'h1, dir[31:16]);
        wr(4'h4, dout[15:0]); wr(4'h5, dout[31:16]);
        for (int k = 0; k < 3; k++) begin
            pad_in = (k == 0) ? 32'hA5A5_3C3C : (k == 1) ? 32'hFFFF_FFFF : 32'h0000_0000;
            tick(3);
            rd32(4'h2, v);
            expv = (dir & dout) | (~dir & pad_in);
            chk($sformatf("R4 data-in pattern %0d", k), v, expv);
        end

        // R9 writes to data-in ignored, unused offsets zero
        wr(4'h2, 16'hFFFF); wr(4'h3, 16'hFFFF);
        rd32(4'h2, v);
        chk("R9 data-in write ignored", v, (dir & dout) | (~dir & pad_in));
        rd32(4'h0, v);
        chk("R9 direction untouched by data-in write", v, dir);
        for (int a = 12; a < 16; a++) begin
            wr(a[3:0], 16'hFFFF);
            rd(a[3:0], r);
            chk($sformatf("R9 unused ofs %0d reads zero", a), {16'd0, r}, 32'd0);
        end

        // R10 latency and idle zero
        bus_en = 1; bus_we = 0; bus_addr = 4'h0;
        chk("R10 no data before edge", {16'd0, bus_rdata}, 32'd0);
        @(posedge clk); @(negedge clk);
        bus_en = 0;
        chk("R10 data one cycle later", {16'd0, bus_rdata}, {16'd0, dir[15:0]});
        tick(1);
        chk("R10 idle reads zero", {16'd0, bus_rdata}, 32'd0);

        // R5/R7 sweep every pin, both edge selects
        wr(4'h0, 16'h0); wr(4'h1, 16'h0);
        pad_in = '0;
        tick(3);
        wr(4'h8, 16'hFFFF); wr(4'h9, 16'hFFFF);
        for (int p = 0; p < 32; p++) begin
            for (int s = 0; s < 2; s++) begin
                wr(4'h6, s[0] ? 16'hFFFF : 16'h0000);
                wr(4'h7, s[0] ? 16'hFFFF : 16'h0000);
                pad_in = 32'd1 << p;
                tick(3);
                rd32(4'hA, v);
                expv = s[0] ? (32'd1 << p) : 32'd0;
                chk($sformatf("R5 pin %0d sel %0d after rise", p, s), v, expv);
                chk($sformatf("R7 irq pin %0d sel %0d after rise", p, s), {31'd0, cpu_irq_n}, {31'd0, ~s[0]});
                pad_in = '0;
                tick(3);
                rd32(4'hA, v);
                chk($sformatf("R5 pin %0d sel %0d after fall", p, s), v, 32'd1 << p);
                wr(4'hA, 16'hFFFF); wr(4'hB, 16'hFFFF);
                chk($sformatf("R7 irq released pin %0d", p), {31'd0, cpu_irq_n}, 32'd1);
            end
        end

        // R5 disabled pins never flag
        wr(4'h8, 16'h0); wr(4'h9, 16'h0);
        pad_in = 32'hFFFF_FFFF; tick(3);
        pad_in = 32'h0; tick(3);
        rd32(4'hA, v);
        chk("R5 disabled pins no flag", v, 32'd0);
        chk("R5 disabled irq released", {31'd0, cpu_irq_n}, 32'd1);

        // R6/R7 sticky flags and partial clears
        wr(4'h6, 16'hFFFF); wr(4'h7, 16'hFFFF);
        wr(4'h8, 16'h0008); wr(4'h9, 16'h0010);
        pad_in = 32'h0010_0008; tick(3);
        pad_in = 32'h0; tick(6);
        rd32(4'hA, v);
        chk("R6 two flags sticky", v, 32'h0010_0008);
        wr(4'hA, 16'h0000); wr(4'hB, 16'h0000);
        rd32(4'hA, v);
        chk("R6 write zero keeps flags", v, 32'h0010_0008);
        wr(4'hA, 16'h0008);
        rd32(4'hA, v);
        chk("R6 clear pin 3 only", v, 32'h0010_0000);
        chk("R7 irq held by pin 20", {31'd0, cpu_irq_n}, 32'd0);
        wr(4'hB, 16'h0010);
        chk("R7 irq released after last clear", {31'd0, cpu_irq_n}, 32'd1);

        // R8 event beats simultaneous clear on pin 5
        wr(4'h8, 16'h0020); wr(4'h9, 16'h0);
        pad_in = 32'h20; tick(3);
        pad_in = 32'h0; tick(4);
        rd32(4'hA, v);
        chk("R8 setup flag", v, 32'h20);
        pad_in = 32'h20;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(4'hA, 16'h0020);
        rd32(4'hA, v);
        chk("R8 event wins over clear", v, 32'h20);
        wr(4'hA, 16'h0020);
        rd32(4'hA, v);
        chk("R8 clear without event", v, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule